// File: doc/BRIEF.md
# Configuration Bit Readback Controller

This block sits beside the program-memory load path of a small microcontroller. It lets firmware read the non-volatile configuration bits, meaning the two lock bits and the low fuse byte, with the ordinary program-memory load operation. Firmware arms a readback mode by writing the self-programming control register with two bits set together. For a short, cycle-counted window after that write, a load returns configuration data in place of the flash byte. The mode turns itself off after one configuration read, after a store strobe, or when the window runs out.

While an EEPROM write is in progress, the control register cannot be written and no configuration read can take place. Outside readback mode, a load passes the flash byte at the pointer address through unchanged. The fuse, lock and flash contents arrive on plain inputs. The result of every load is registered and comes out one cycle after the request.

Top module: `cfgrd_top`

## Requirements
- R1: A control write (`regWrEn` high, `eepromBusy` low) with bit 3 (read-config) and bit 0 (self-program enable) both set turns readback mode on from the next cycle. A control write with either bit clear leaves the mode off, or turns it off.
- R2: A load issued in any of the three cycles that follow the arming write returns configuration data. A load issued in the fourth cycle or later returns the flash byte, because the mode has already expired.
- R3: A readback load at pointer 0x0000 returns `fuseLow[7:0]` unchanged in bits 7..0. A programmed cell arrives as 0 and an unprogrammed one as 1, and both read back with that same level.
- R4: A readback load at pointer 0x0001 returns `lockBits[1]` (lock bit 2) in data bit 1, `lockBits[0]` (lock bit 1) in data bit 0, and 1 in bits 7..2.
- R5: A readback load at any pointer other than 0x0000 and 0x0001 returns 0xFF.
- R6: A load made while readback mode is on ends the mode, so the next load returns the flash byte.
- R7: A store strobe while readback mode is on ends the mode, so a load in the next cycle returns the flash byte.
- R8: While `eepromBusy` is high, control writes have no effect and a load returns the flash byte, even if the mode was armed beforehand.
- R9: With readback mode off, a load returns `flashData`, and `flashAddr` always equals `loadAddr`.
- R10: `readData` and `readValid` are registered. `readValid` is high exactly in the cycle after a cycle in which `loadReq` was high. After reset the mode is off, `readValid` is 0 and `readData` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for the self-programming control register |
| regWrData | input | 8 | Control write value (bit 3 read-config, bit 0 self-program enable) |
| loadReq | input | 1 | Program-memory load request |
| loadAddr | input | 16 | Load pointer address |
| storeStrobe | input | 1 | Store-instruction strobe |
| eepromBusy | input | 1 | High while an EEPROM write is in progress |
| fuseLow | input | 8 | Low fuse byte cell levels |
| lockBits | input | 2 | Lock bit cell levels (bit 1 = lock bit 2) |
| flashAddr | output | 16 | Flash read address |
| flashData | input | 8 | Flash byte at `flashAddr` |
| readData | output | 8 | Registered load result |
| readValid | output | 1 | `readData` is valid this cycle |

## Verification
The hardest point to reach from the ports is the edge of the load window. The load must land exactly in the third or the fourth cycle after the arming write, and those two cycles give different results. The bench re-arms before every vector and then waits a swept number of cycles (one to four) before issuing the load, across every fuse byte and every lock pattern. A second load sent straight after each readback confirms that the mode was released. Separate sequences arm the mode and then raise the busy flag or pulse the store strobe before the load.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 16;
  localparam int LOCK_W = 2;

  // Strobes from arming control to the datapath for one load.
  typedef struct packed {
    logic capture;   // a load is being answered this cycle
    logic selFuse;   // answer with the fuse byte
    logic selLock;   // answer with the lock word
    logic selBlank;  // answer with all ones
  } rbStrobe_t;
endpackage

// File: rtl/cfgrd_arm_ctrl.sv
module cfgrd_arm_ctrl
  import cfgrd_pkg::*;
#(
  parameter int LOAD_WIN  = 3,
  parameter int STORE_WIN = 4,
  parameter int RDCFG_BIT = 3,
  parameter int SPEN_BIT  = 0,
  parameter logic [ADDR_W-1:0] FUSE_ADDR = 16'h0000,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 16'h0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              loadReq,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic              storeStrobe,
  input  logic              eepromBusy,
  output rbStrobe_t         strobes
);
  localparam int CNT_W = $clog2((LOAD_WIN > STORE_WIN ? LOAD_WIN : STORE_WIN) + 1);
  localparam logic [CNT_W-1:0] LOAD_LAST  = CNT_W'(LOAD_WIN - 1);
  localparam logic [CNT_W-1:0] STORE_LAST = CNT_W'(STORE_WIN - 1);

  logic             armed;
  logic [CNT_W-1:0] loadAge;
  logic [CNT_W-1:0] storeAge;

  logic wrAccept, armReq, cfgLoad, loadExpire, storeExpire, endMode;

  assign wrAccept    = regWrEn && !eepromBusy;
  assign armReq      = wrAccept && regWrData[RDCFG_BIT] && regWrData[SPEN_BIT];
  assign cfgLoad     = armed && loadReq && !eepromBusy;
  assign loadExpire  = armed && !loadReq && (loadAge == LOAD_LAST);
  assign storeExpire = armed && !storeStrobe && (storeAge == STORE_LAST);
  assign endMode     = armed && (loadReq || storeStrobe || loadExpire || storeExpire);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed    <= 1'b0;
      loadAge  <= '0;
      storeAge <= '0;
    end else if (wrAccept) begin
      armed    <= armReq;
      loadAge  <= '0;
      storeAge <= '0;
    end else if (endMode) begin
      armed    <= 1'b0;
      loadAge  <= '0;
      storeAge <= '0;
    end else if (armed) begin
      loadAge  <= loadAge + 1'b1;
      storeAge <= storeAge + 1'b1;
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.capture  = loadReq;
    if (cfgLoad) begin
      strobes.selFuse  = (loadAddr == FUSE_ADDR);
      strobes.selLock  = (loadAddr == LOCK_ADDR);
      strobes.selBlank = (loadAddr != FUSE_ADDR) && (loadAddr != LOCK_ADDR);
    end
  end

  // R2: the mode never outlives its load window
  assert_load_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (loadAge < CNT_W'(LOAD_WIN)));

  // R6: a load while armed releases the mode unless re-armed in the same cycle
  assert_release_on_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    (armed && loadReq && !wrAccept) |=> !armed);

  // R7: a store strobe while armed releases the mode
  assert_release_on_store_R7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && storeStrobe && !wrAccept) |=> !armed);

  // R8: a control write while busy cannot arm the mode
  assert_busy_blocks_arm_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && regWrEn && eepromBusy) |=> !armed);

  // R1: arming only through an accepted write with both bits set
  assert_arm_source_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armed) |-> $past(regWrEn && !eepromBusy &&
                           regWrData[RDCFG_BIT] && regWrData[SPEN_BIT]));

  // R3/R4/R5: at most one source chosen per load
  assert_onehot_select_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.selFuse, strobes.selLock, strobes.selBlank}));
endmodule

// File: rtl/cfgrd_datapath.sv
module cfgrd_datapath
  import cfgrd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rbStrobe_t         strobes,
  input  logic [DATA_W-1:0] fuseLow,
  input  logic [LOCK_W-1:0] lockBits,
  input  logic [DATA_W-1:0] flashData,
  output logic [DATA_W-1:0] readData,
  output logic              readValid
);
  logic [DATA_W-1:0] lockWord;
  logic [DATA_W-1:0] nextData;

  // Lock word: cell levels in the low bits, ones above.
  for (genvar b = 0; b < DATA_W; b++) begin : g_lockWord
    if (b < LOCK_W) begin : g_cell
      assign lockWord[b] = lockBits[b];
    end else begin : g_fill
      assign lockWord[b] = 1'b1;
    end
  end

  always_comb begin
    if (strobes.selFuse)       nextData = fuseLow;
    else if (strobes.selLock)  nextData = lockWord;
    else if (strobes.selBlank) nextData = '1;
    else                       nextData = flashData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readData  <= '0;
      readValid <= 1'b0;
    end else begin
      readValid <= strobes.capture;
      if (strobes.capture) readData <= nextData;
    end
  end

  // R10: valid follows a load by exactly one cycle
  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> readValid);
  assert_valid_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> !readValid);

  // R9: a load with no readback select returns the flash byte
  assert_flash_pass_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !strobes.selFuse && !strobes.selLock && !strobes.selBlank)
      |=> (readData == $past(flashData)));
endmodule

// File: rtl/cfgrd_top.sv
module cfgrd_top
  import cfgrd_pkg::*;
#(
  parameter int LOAD_WIN  = 3,
  parameter int STORE_WIN = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [7:0]  regWrData,
  input  logic        loadReq,
  input  logic [15:0] loadAddr,
  input  logic        storeStrobe,
  input  logic        eepromBusy,
  input  logic [7:0]  fuseLow,
  input  logic [1:0]  lockBits,
  output logic [15:0] flashAddr,
  input  logic [7:0]  flashData,
  output logic [7:0]  readData,
  output logic        readValid
);
  rbStrobe_t strobes;

  assign flashAddr = loadAddr;

  cfgrd_arm_ctrl #(
    .LOAD_WIN (LOAD_WIN),
    .STORE_WIN(STORE_WIN)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .loadReq    (loadReq),
    .loadAddr   (loadAddr),
    .storeStrobe(storeStrobe),
    .eepromBusy (eepromBusy),
    .strobes    (strobes)
  );

  cfgrd_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .fuseLow  (fuseLow),
    .lockBits (lockBits),
    .flashData(flashData),
    .readData (readData),
    .readValid(readValid)
  );
endmodule

// File: tb/cfgrd_top_tb.sv
module cfgrd_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic        loadReq = 1'b0;
  logic [15:0] loadAddr = '0;
  logic        storeStrobe = 1'b0;
  logic        eepromBusy = 1'b0;
  logic [7:0]  fuseLow = 8'hFF;
  logic [1:0]  lockBits = 2'b11;
  logic [15:0] flashAddr;
  logic [7:0]  flashData;
  logic [7:0]  readData;
  logic        readValid;

  int vecCount = 0;
  int errCount = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [7:0] flashModel(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5A;
  endfunction

  assign flashData = flashModel(flashAddr);

  cfgrd_top dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .loadReq(loadReq), .loadAddr(loadAddr), .storeStrobe(storeStrobe),
    .eepromBusy(eepromBusy), .fuseLow(fuseLow), .lockBits(lockBits),
    .flashAddr(flashAddr), .flashData(flashData), .readData(readData),
    .readValid(readValid)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vecCount++;
    if (got !== exp) begin
      errCount++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  // Control write for one cycle.
  task automatic ctrlWrite(input logic [7:0] v);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  // Load issued in the current cycle; result sampled one cycle later.
  task automatic doLoad(input logic [15:0] a, output logic [7:0] d, output logic v);
    loadReq = 1'b1; loadAddr = a;
    @(negedge clk);
    loadReq = 1'b0;
    d = readData; v = readValid;
  endtask

  // Arm, wait so the load lands in cycle 'dly' after the write, load.
  task automatic armLoad(input int dly, input logic [15:0] a, output logic [7:0] d);
    logic v;
    ctrlWrite(8'h09);
    repeat (dly - 1) @(negedge clk);
    doLoad(a, d, v);
    check("R10 valid", {7'd0, v}, 8'd1);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic v;
    repeat (3) @(negedge clk);
    check("R10 reset data", readData, 8'h00);
    check("R10 reset valid", {7'd0, readValid}, 8'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 idle valid", {7'd0, readValid}, 8'd0);

    // R9: plain loads sweep
    for (int i = 0; i < 96; i++) begin
      logic [15:0] a = (i < 64) ? 16'(i) : 16'(i * 16'h0A31);
      doLoad(a, d, v);
      check("R9 flash", d, flashModel(a));
      check("R10 valid", {7'd0, v}, 8'd1);
    end
    @(negedge clk);
    check("R10 valid drops", {7'd0, readValid}, 8'd0);

    // R3 / R2 / R6: fuse byte across the window edge
    for (int f = 0; f < 256; f++) begin
      for (int dly = 1; dly <= 4; dly++) begin
        fuseLow = 8'(f);
        armLoad(dly, 16'h0000, d);
        if (dly <= 3) check("R3 fuse", d, 8'(f));
        else          check("R2 window expired", d, flashModel(16'h0000));
        doLoad(16'h0000, d, v);
        check("R6 released", d, flashModel(16'h0000));
      end
    end

    // R4: lock word
    for (int l = 0; l < 4; l++) begin
      for (int dly = 1; dly <= 4; dly++) begin
        lockBits = 2'(l);
        armLoad(dly, 16'h0001, d);
        if (dly <= 3) check("R4 lock", d, {6'h3F, 2'(l)});
        else          check("R2 window expired", d, flashModel(16'h0001));
        doLoad(16'h0001, d, v);
        check("R6 released", d, flashModel(16'h0001));
      end
    end

    // R5: other pointers while armed
    for (int i = 0; i < 24; i++) begin
      logic [15:0] a = 16'(2 + i * 16'h0AB7);
      armLoad(1 + (i % 3), a, d);
      check("R5 blank", d, 8'hFF);
    end

    // R1: single-bit and empty writes do not arm; disarming write
    fuseLow = 8'h3C;
    foreach (d[k]) begin end
    begin
      logic [7:0] vals[3] = '{8'h08, 8'h01, 8'h00};
      for (int k = 0; k < 3; k++) begin
        ctrlWrite(vals[k]);
        doLoad(16'h0000, d, v);
        check("R1 not armed", d, flashModel(16'h0000));
      end
    end
    ctrlWrite(8'h09);
    ctrlWrite(8'h08);
    doLoad(16'h0000, d, v);
    check("R1 disarm write", d, flashModel(16'h0000));
    ctrlWrite(8'hFF);
    doLoad(16'h0000, d, v);
    check("R1 arm with extra bits", d, 8'h3C);

    // R7: store strobe releases the mode
    for (int dly = 1; dly <= 2; dly++) begin
      ctrlWrite(8'h09);
      repeat (dly - 1) @(negedge clk);
      storeStrobe = 1'b1;
      @(negedge clk);
      storeStrobe = 1'b0;
      doLoad(16'h0000, d, v);
      check("R7 store release", d, flashModel(16'h0000));
    end

    // R8: busy blocks arming writes
    eepromBusy = 1'b1;
    ctrlWrite(8'h09);
    eepromBusy = 1'b0;
    doLoad(16'h0000, d, v);
    check("R8 write blocked", d, flashModel(16'h0000));
    // R8: busy while armed blocks the read
    ctrlWrite(8'h09);
    eepromBusy = 1'b1;
    doLoad(16'h0000, d, v);
    check("R8 read blocked", d, flashModel(16'h0000));
    // R8: disarming write while busy is ignored
    eepromBusy = 1'b0;
    ctrlWrite(8'h09);
    eepromBusy = 1'b1;
    regWrEn = 1'b1; regWrData = 8'h00;
    @(negedge clk);
    regWrEn = 1'b0; eepromBusy = 1'b0;
    doLoad(16'h0000, d, v);
    check("R8 busy write ignored", d, 8'h3C);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end
endmodule